// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode, funct3 and funct7 fields of the current instruction into the control word for a single-cycle load/store datapath. The control word has six one-bit enables and a 4-bit ALU operation code. The datapath uses these signals to choose the second ALU operand, to enable data-memory reads and writes, to pick the write-back source, to enable the register write and to mark a conditional branch. The block is purely combinational. The control word settles within the cycle in which the instruction fields are presented.

Decoding happens at two levels. A main decoder looks only at the opcode. It produces the six enables and a 2-bit ALU class. An ALU-control stage then combines that class with funct3 and funct7 to produce the final ALU code. Five instructions are supported: register add, register subtract, load doubleword, store doubleword and branch-if-equal. Any other opcode gives a harmless no-operation word, which enables no write and no branch.

Top module: `ctrl_decoder`

## Requirements
- R1: `branch_o` is 1 when the opcode is 1100011 (branch-if-equal) and 0 for every other opcode.
- R2: `mem_rd_o` is 1 only when the opcode is 0000011 (load). `mem_wr_o` is 1 only when the opcode is 0100011 (store).
- R3: `mem_rd_o` and `mem_wr_o` are never both 1, for any of the 128 opcode values.
- R4: `alu_src_o` is 1 (immediate operand) for load and store. It is 0 (second register operand) for the R-type opcode 0110011 and for branch.
- R5: `reg_wr_o` is 1 for R-type and load. It is 0 for store and branch.
- R6: `mem_to_reg_o` is 1 only for load.
- R7: For load and store, `alu_code_o` is 0010 (add), whatever funct3 and funct7 hold.
- R8: For branch, `alu_code_o` is 0110 (subtract), whatever funct3 and funct7 hold. The datapath uses the subtraction to test the two operands for equality.
- R9: For R-type, `alu_code_o` is 0110 when funct7 bit 5 is 1 and funct3 is 000. For every other funct combination it is 0010.
- R10: For any opcode other than the four listed, all six enables are 0 and `alu_code_o` is 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Opcode field of the current instruction |
| funct3_i | input | 3 | funct3 field |
| funct7_i | input | 7 | funct7 field |
| branch_o | output | 1 | Conditional branch instruction |
| mem_rd_o | output | 1 | Data-memory read enable |
| mem_wr_o | output | 1 | Data-memory write enable |
| alu_src_o | output | 1 | 1 selects the immediate as the second ALU operand |
| mem_to_reg_o | output | 1 | 1 selects memory data for write-back |
| reg_wr_o | output | 1 | Destination register write enable |
| alu_code_o | output | 4 | ALU operation: 0010 add, 0110 subtract |

## Verification
The checker evaluates its assertions whenever the instruction fields change. It therefore assumes that the three fields are driven together, as one instruction, and are never updated piecemeal across a settle. The bench keeps to this by updating all three fields in the same statement sequence, away from the clock edge, and it reads the outputs only after they have settled. No X or Z is driven on any field, so every check sees a defined opcode. This includes the sweep over all 128 opcode values with varied function fields.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int ALUC_W = 4;
    localparam int SUB_BIT = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_RTYPE  = 7'b0110011,
        OPC_LOAD   = 7'b0000011,
        OPC_STORE  = 7'b0100011,
        OPC_BRANCH = 7'b1100011
    } opc_e;

    typedef enum logic [1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10,
        AOP_RSVD = 2'b11
    } aluop_e;

    localparam logic [ALUC_W-1:0] ALU_ADD = 4'b0010;
    localparam logic [ALUC_W-1:0] ALU_SUB = 4'b0110;

    typedef struct packed {
        logic   branch;
        logic   mem_rd;
        logic   mem_wr;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_wr;
        aluop_e alu_op;
    } main_ctrl_t;

    localparam main_ctrl_t CTRL_NOP = '{
        branch: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, alu_src: 1'b0,
        mem_to_reg: 1'b0, reg_wr: 1'b0, alu_op: AOP_ADD
    };

    function automatic main_ctrl_t decode_main(input logic [OPC_W-1:0] opc);
        main_ctrl_t c;
        c = CTRL_NOP;
        case (opc)
            OPC_RTYPE: begin
                c.reg_wr = 1'b1;
                c.alu_op = AOP_FUNC;
            end
            OPC_LOAD: begin
                c.mem_rd     = 1'b1;
                c.alu_src    = 1'b1;
                c.mem_to_reg = 1'b1;
                c.reg_wr     = 1'b1;
                c.alu_op     = AOP_ADD;
            end
            OPC_STORE: begin
                c.mem_wr  = 1'b1;
                c.alu_src = 1'b1;
                c.alu_op  = AOP_ADD;
            end
            OPC_BRANCH: begin
                c.branch = 1'b1;
                c.alu_op = AOP_SUB;
            end
            default: c = CTRL_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctrl_main_decoder.sv
module ctrl_main_decoder
    import ctrl_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output main_ctrl_t       ctrl_o
);

    always_comb begin
        ctrl_o = decode_main(opcode_i);
    end

endmodule

// File: rtl/ctrl_alu_control.sv
module ctrl_alu_control
    import ctrl_dec_pkg::*;
(
    input  aluop_e            alu_op_i,
    input  logic [F3_W-1:0]   funct3_i,
    input  logic [F7_W-1:0]   funct7_i,
    output logic [ALUC_W-1:0] alu_code_o
);

    logic func_sub;
    logic unused_funct7;

    // Only the alternate-operation bit of funct7 matters here
    assign func_sub      = funct7_i[SUB_BIT] && (funct3_i == '0);
    assign unused_funct7 = ^{funct7_i[F7_W-1:SUB_BIT+1], funct7_i[SUB_BIT-1:0]};

    always_comb begin
        unique case (alu_op_i)
            AOP_ADD:  alu_code_o = ALU_ADD;
            AOP_SUB:  alu_code_o = ALU_SUB;
            AOP_FUNC: alu_code_o = func_sub ? ALU_SUB : ALU_ADD;
            default:  alu_code_o = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import ctrl_dec_pkg::*;
(
    input  logic [6:0] opcode_i,
    input  logic [2:0] funct3_i,
    input  logic [6:0] funct7_i,
    output logic       branch_o,
    output logic       mem_rd_o,
    output logic       mem_wr_o,
    output logic       alu_src_o,
    output logic       mem_to_reg_o,
    output logic       reg_wr_o,
    output logic [3:0] alu_code_o
);

    main_ctrl_t main_ctrl;

    ctrl_main_decoder u_main (
        .opcode_i (opcode_i),
        .ctrl_o   (main_ctrl)
    );

    ctrl_alu_control u_aluctl (
        .alu_op_i   (main_ctrl.alu_op),
        .funct3_i   (funct3_i),
        .funct7_i   (funct7_i),
        .alu_code_o (alu_code_o)
    );

    assign branch_o     = main_ctrl.branch;
    assign mem_rd_o     = main_ctrl.mem_rd;
    assign mem_wr_o     = main_ctrl.mem_wr;
    assign alu_src_o    = main_ctrl.alu_src;
    assign mem_to_reg_o = main_ctrl.mem_to_reg;
    assign reg_wr_o     = main_ctrl.reg_wr;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
    input logic [6:0] opcode_i,
    input logic [2:0] funct3_i,
    input logic [6:0] funct7_i,
    input logic       branch_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       alu_src_o,
    input logic       mem_to_reg_o,
    input logic       reg_wr_o,
    input logic [3:0] alu_code_o
);

    logic supported;
    assign supported = (opcode_i == 7'b0110011) || (opcode_i == 7'b0000011) ||
                       (opcode_i == 7'b0100011) || (opcode_i == 7'b1100011);

    always_comb begin
        p_mem_excl_r3: assert (!(mem_rd_o && mem_wr_o))
            else $error("R3 read and write both asserted");
        p_branch_opc_r1: assert (!branch_o || opcode_i == 7'b1100011)
            else $error("R1 branch on wrong opcode");
        p_branch_sub_r8: assert (!branch_o || alu_code_o == 4'b0110)
            else $error("R8 branch without subtract");
        p_mem_imm_r4: assert (!(mem_rd_o || mem_wr_o) || alu_src_o)
            else $error("R4 memory access without immediate");
        p_mem_add_r7: assert (!(mem_rd_o || mem_wr_o) || alu_code_o == 4'b0010)
            else $error("R7 memory access without add");
        p_wb_load_r6: assert (!mem_to_reg_o || (mem_rd_o && reg_wr_o))
            else $error("R6 memory write-back outside load");
        p_no_rw_r5: assert (!(mem_wr_o || branch_o) || !reg_wr_o)
            else $error("R5 register write on store or branch");
        p_nop_r10: assert (supported ||
                           !(branch_o || mem_rd_o || mem_wr_o || alu_src_o ||
                             mem_to_reg_o || reg_wr_o))
            else $error("R10 enable on unsupported opcode");
    end

    logic unused_chk;
    assign unused_chk = ^{funct3_i, funct7_i};

endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
    .opcode_i     (opcode_i),
    .funct3_i     (funct3_i),
    .funct7_i     (funct7_i),
    .branch_o     (branch_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .alu_src_o    (alu_src_o),
    .mem_to_reg_o (mem_to_reg_o),
    .reg_wr_o     (reg_wr_o),
    .alu_code_o   (alu_code_o)
);

// File: tb/ctrl_decoder_test.sv
`timescale 1ns/1ps
module ctrl_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;
    logic       branch, mem_rd, mem_wr, alu_src, mem_to_reg, reg_wr;
    logic [3:0] alu_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ctrl_decoder uut (
        .opcode_i     (opcode),
        .funct3_i     (funct3),
        .funct7_i     (funct7),
        .branch_o     (branch),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .alu_src_o    (alu_src),
        .mem_to_reg_o (mem_to_reg),
        .reg_wr_o     (reg_wr),
        .alu_code_o   (alu_code)
    );

    // Expected word {branch, rd, wr, src, m2r, rw, code[3:0]} from the requirements
    function automatic logic [9:0] model(input logic [6:0] op, input logic [2:0] f3,
                                         input logic [6:0] f7);
        case (op)
            7'b0110011: return {6'b000001, (f7[5] && f3 == 3'b000) ? 4'b0110 : 4'b0010};
            7'b0000011: return {6'b010111, 4'b0010};
            7'b0100011: return {6'b001100, 4'b0010};
            7'b1100011: return {6'b100000, 4'b0110};
            default:    return {6'b000000, 4'b0010};
        endcase
    endfunction

    task automatic apply(input logic [6:0] op, input logic [2:0] f3, input logic [6:0] f7);
        @(negedge clk);
        opcode = op;
        funct3 = f3;
        funct7 = f7;
        #2;
    endtask

    task automatic check(input string tag);
        logic [9:0] act, exp;
        act = {branch, mem_rd, mem_wr, alu_src, mem_to_reg, reg_wr, alu_code};
        exp = model(opcode, funct3, funct7);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s opcode=%b f3=%b f7=%b actual=%b expected=%b",
                     tag, opcode, funct3, funct7, act, exp);
        end
    endtask

    task automatic t_reset_state();
        apply(7'b0000000, 3'b000, 7'b0000000);
        check("R10 idle word after reset");
    endtask

    task automatic t_rtype();
        apply(7'b0110011, 3'b000, 7'b0000000); check("R9 R5 R4 add");
        apply(7'b0110011, 3'b000, 7'b0100000); check("R9 sub");
        apply(7'b0110011, 3'b001, 7'b0100000); check("R9 funct3 nonzero stays add");
        apply(7'b0110011, 3'b000, 7'b1011111); check("R9 bit5 clear stays add");
        apply(7'b0110011, 3'b000, 7'b1111111); check("R9 all funct7 set");
    endtask

    task automatic t_load();
        apply(7'b0000011, 3'b011, 7'b0000000); check("R2 R6 R7 load");
        apply(7'b0000011, 3'b000, 7'b0100000); check("R7 load ignores funct");
    endtask

    task automatic t_store();
        apply(7'b0100011, 3'b011, 7'b0000000); check("R2 R4 R5 store");
        apply(7'b0100011, 3'b000, 7'b0100000); check("R7 store ignores funct");
    endtask

    task automatic t_branch();
        apply(7'b1100011, 3'b000, 7'b0000000); check("R1 R8 branch");
        apply(7'b1100011, 3'b111, 7'b1111111); check("R8 branch ignores funct");
    endtask

    task automatic t_unsupported();
        apply(7'b0010011, 3'b000, 7'b0100000); check("R10 immediate-ALU opcode");
        apply(7'b1101111, 3'b000, 7'b0000000); check("R10 jump opcode");
        apply(7'b1111111, 3'b111, 7'b1111111); check("R10 all ones");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 128; i++) begin
            apply(i[6:0], i[2:0], {i[0], i[1], i[2], i[3], i[4], i[5], i[6]});
            check("R1 R2 R3 R10 sweep");
            checks++;
            if (mem_rd && mem_wr) begin
                errors++;
                $display("FAIL R3 opcode=%b actual rd=%b wr=%b expected not both",
                         opcode, mem_rd, mem_wr);
            end
        end
    endtask

    initial begin
        opcode = '0;
        funct3 = '0;
        funct7 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_rtype();
        t_load();
        t_store();
        t_branch();
        t_unsupported();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule